// File: doc/BRIEF.md
# I2C Register-File Target

This block is the device end of a two-wire serial bus. It holds a small bank of 8-bit registers behind a fixed 7-bit device address. The block oversamples the clock and data lines with its own system clock and finds bus start, repeated start and stop events. It accepts an address byte and answers with an acknowledge only when the address matches its own. It never drives the data line high. Its single output is a pull-low enable, which an open-drain pad uses to acknowledge bytes and to return read data.

A parameter selects the register addressing. In multi-register mode the first byte written after the address selects a register pointer. Later written bytes land at the pointer, and read bytes come from it. The pointer steps by one after every byte, so bursts run through consecutive registers. The pointer survives a repeated start, which gives the usual "set pointer, then read" sequence. In single-register mode no pointer byte exists. Every written byte goes into the one register, and every read returns it.

Top module: `i2c_reg_target`

## Requirements
- R1: Before it sees its own address after a start or repeated start, the target never asserts `sdaPullLow`. After any other address it stays released until the next start.
- R2: A start is an SDA fall while SCL is high, and a stop is an SDA rise while SCL is high. A start that comes before any stop (a repeated start) restarts address matching.
- R3: Bits are taken on SCL high, most significant bit first. The address byte is {address[6:0], direction}, and direction 1 means read.
- R4: After each accepted byte the target asserts `sdaPullLow` during the low phase of the 9th clock and keeps it asserted through that clock's high phase.
- R5: In a write (direction 0) in multi-register mode, the first data byte loads the pointer. Each later byte is stored at the pointer, and the pointer then increments.
- R6: A pointer byte of NUM_REGS or more is not acknowledged. A data byte written while the pointer is at NUM_REGS is neither acknowledged nor stored. In both cases the target goes idle.
- R7: In a read (direction 1), the target shifts out the register at the pointer, MSB first. It increments the pointer after each byte and releases SDA for the 9th clock.
- R8: When the master does not acknowledge a read byte, the target releases SDA. Further clocks read all ones until the next start.
- R9: The pointer keeps its value across a repeated start and across a stop.
- R10: In single-register mode, the bytes after a write address go straight into the one register, each of them acknowledged. Every byte read returns that register.
- R11: A read with the pointer at NUM_REGS returns 0xFF.
- R12: Apart from start and stop events, `sdaPullLow` changes only while SCL is low.
- R13: A stop leaves the target idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to oversample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaPullLow | output | 1 | 1 = pull the data line low, 0 = release it |

## Verification
A wrong pointer shows at the ports in the first data byte of the next read. The expected value and the value read back then differ in at least one bit within eight bus clocks. A wrong acknowledge decision shows one bit later than the byte it belongs to, as the 9th-clock level on the data line. A target that does not go idle after a mismatch, a NACK or a stop shows as a pull-low seen during a window in which the reference expects silence. The bench counts such pull-lows on every system clock.

// File: rtl/i2c_reg_target_pkg.sv
package i2c_reg_target_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } busState_t;

  // strobes from control to the register datapath
  typedef struct packed {
    logic       setPtr;
    logic       writeReg;
    logic       incPtr;
    logic [7:0] byteVal;
  } dpStrobe_t;

endpackage

// File: rtl/i2c_reg_target_dp.sv
module i2c_reg_target_dp
  import i2c_reg_target_pkg::*;
#(
  parameter int NUM_REGS   = 4,
  parameter bit SINGLE_REG = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  strobe,
  output logic       ptrValid,
  output logic [7:0] rdData
);

  localparam int PTR_W = $clog2(NUM_REGS + 1);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [PTR_W-1:0] ptr;
  logic [IDX_W-1:0] idx;
  logic [7:0]       regFile [NUM_REGS];

  generate
    if (SINGLE_REG) begin : gSingle
      assign ptr = '0;
      assign ptrValid = 1'b1;
    end else begin : gMulti
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          ptr <= '0;
        end else if (strobe.setPtr) begin
          ptr <= strobe.byteVal[PTR_W-1:0];
        end else if (strobe.incPtr && (ptr < PTR_W'(NUM_REGS))) begin
          ptr <= ptr + 1'b1;
        end
      end
      assign ptrValid = (ptr < PTR_W'(NUM_REGS));
    end
  endgenerate

  assign idx = ptr[IDX_W-1:0];

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          regFile[g] <= 8'h00;
        end else if (strobe.writeReg && (idx == IDX_W'(g))) begin
          regFile[g] <= strobe.byteVal;
        end
      end
    end
  endgenerate

  assign rdData = ptrValid ? regFile[idx] : 8'hFF;

  // R6: the pointer never runs past one beyond the last register
  assert_ptr_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    ptr <= PTR_W'(NUM_REGS));

  // R6: a store never happens at an invalid pointer
  assert_wr_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeReg |-> ptrValid);

endmodule

// File: rtl/i2c_reg_target_ctrl.sv
module i2c_reg_target_ctrl
  import i2c_reg_target_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h2A,
  parameter int         NUM_REGS   = 4,
  parameter bit         SINGLE_REG = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       ptrValid,
  input  logic [7:0] rdData,
  output dpStrobe_t  strobe,
  output logic       sdaPullLow
);

  logic [1:0] sclSync, sdaSync;
  logic       sclPrev, sdaPrev;
  logic       sclS, sdaS, sclRise, sclFall, startDet, stopDet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  assign sclS     = sclSync[1];
  assign sdaS     = sdaSync[1];
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

  busState_t  state;
  logic [3:0] bitCnt;
  logic [7:0] shiftReg;
  logic       isRead, firstByte, masterAck;
  logic       rxDone, ptrPhase, ptrOk, acceptRx, txLast;

  assign rxDone   = (state == ST_RX) && sclFall && (bitCnt == 4'd8);
  assign ptrPhase = firstByte && !SINGLE_REG;
  assign ptrOk    = ({24'd0, shiftReg} < 32'(NUM_REGS));
  assign acceptRx = ptrPhase ? ptrOk : ptrValid;
  assign txLast   = (state == ST_TX) && sclFall && (bitCnt == 4'd7);

  always_comb begin
    strobe.setPtr   = rxDone && ptrPhase && ptrOk;
    strobe.writeReg = rxDone && !ptrPhase && ptrValid;
    strobe.incPtr   = strobe.writeReg || txLast;
    strobe.byteVal  = shiftReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      shiftReg   <= '0;
      isRead     <= 1'b0;
      firstByte  <= 1'b0;
      masterAck  <= 1'b0;
      sdaPullLow <= 1'b0;
    end else if (stopDet) begin
      state      <= ST_IDLE;
      sdaPullLow <= 1'b0;
    end else if (startDet) begin
      state      <= ST_ADDR;
      bitCnt     <= '0;
      firstByte  <= 1'b1;
      sdaPullLow <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_RX: begin
          if (sclRise) begin
            shiftReg <= {shiftReg[6:0], sdaS};
            bitCnt   <= bitCnt + 1'b1;
          end else if (sclFall && bitCnt == 4'd8) begin
            if (state == ST_ADDR) begin
              if (shiftReg[7:1] == DEV_ADDR) begin
                state      <= ST_ADDR_ACK;
                isRead     <= shiftReg[0];
                sdaPullLow <= 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end else if (acceptRx) begin
              state      <= ST_RX_ACK;
              firstByte  <= 1'b0;
              sdaPullLow <= 1'b1;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            bitCnt <= '0;
            if (isRead) begin
              state      <= ST_TX;
              shiftReg   <= rdData;
              sdaPullLow <= ~rdData[7];
            end else begin
              state      <= ST_RX;
              sdaPullLow <= 1'b0;
            end
          end
        end
        ST_RX_ACK: begin
          if (sclFall) begin
            state      <= ST_RX;
            bitCnt     <= '0;
            sdaPullLow <= 1'b0;
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              state      <= ST_TX_ACK;
              sdaPullLow <= 1'b0;
            end else begin
              shiftReg   <= {shiftReg[6:0], 1'b0};
              sdaPullLow <= ~shiftReg[6];
              bitCnt     <= bitCnt + 1'b1;
            end
          end
        end
        ST_TX_ACK: begin
          if (sclRise) begin
            masterAck <= ~sdaS;
          end else if (sclFall) begin
            if (masterAck) begin
              state      <= ST_TX;
              bitCnt     <= '0;
              shiftReg   <= rdData;
              sdaPullLow <= ~rdData[7];
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: acknowledge held low through the high phase of the 9th clock
  assert_ack_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_ADDR_ACK) || (state == ST_RX_ACK)) && sclS |-> sdaPullLow);

  // R12: outside start/stop handling the drive only moves with SCL low
  assert_sda_low_phase_R12: assert property (@(posedge clk) disable iff (!rstN)
    (sdaPullLow != $past(sdaPullLow)) && !$past(startDet) && !$past(stopDet)
      |-> !$past(sclS));

  // R13: a stop leaves the target idle and released
  assert_stop_release_R13: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (state == ST_IDLE) && !sdaPullLow);

  // R1: no drive while idle
  assert_idle_silent_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaPullLow);

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_reg_target_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h2A,
  parameter int         NUM_REGS   = 4,
  parameter bit         SINGLE_REG = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaPullLow
);

  dpStrobe_t  strobe;
  logic       ptrValid;
  logic [7:0] rdData;

  i2c_reg_target_ctrl #(
    .DEV_ADDR  (DEV_ADDR),
    .NUM_REGS  (NUM_REGS),
    .SINGLE_REG(SINGLE_REG)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .ptrValid  (ptrValid),
    .rdData    (rdData),
    .strobe    (strobe),
    .sdaPullLow(sdaPullLow)
  );

  i2c_reg_target_dp #(
    .NUM_REGS  (NUM_REGS),
    .SINGLE_REG(SINGLE_REG)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .ptrValid(ptrValid),
    .rdData  (rdData)
  );

endmodule

// File: tb/i2c_reg_target_test.sv
module i2c_reg_target_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic pullMulti, pullOne;
  logic sdaBus;

  always #4 clk = ~clk;

  assign sdaBus = sdaM & ~pullMulti & ~pullOne;

  i2c_reg_target #(.DEV_ADDR(7'h2A), .NUM_REGS(4), .SINGLE_REG(1'b0)) uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .sdaPullLow(pullMulti));

  i2c_reg_target #(.DEV_ADDR(7'h51), .NUM_REGS(1), .SINGLE_REG(1'b1)) uutOne (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .sdaPullLow(pullOne));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit quiet = 1'b0;
  int quietHits = 0;
  int lowPhaseHits = 0;
  logic [4:0] sclHist = 5'b11111;
  logic pullLast = 1'b0;

  // reference state
  logic [7:0] mRegs [4];
  int         mPtr = 0;
  logic [7:0] mOne = 8'h00;

  // every-clock monitors: silence windows (R1) and drive-while-high (R12)
  always @(negedge clk) begin
    if (quiet && pullMulti) quietHits++;
    if (rstN && (&sclHist) && sclM && (pullMulti != pullLast)) lowPhaseHits++;
    sclHist  <= {sclHist[3:0], sclM};
    pullLast <= pullMulti;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic waitHalf();
    repeat (8) @(negedge clk);
  endtask

  task automatic startCond();
    sdaM = 1'b1; waitHalf();
    sclM = 1'b1; waitHalf();
    sdaM = 1'b0; waitHalf();
    sclM = 1'b0; repeat (2) @(negedge clk);
  endtask

  task automatic stopCond();
    sdaM = 1'b0; waitHalf();
    sclM = 1'b1; waitHalf();
    sdaM = 1'b1; waitHalf();
  endtask

  task automatic writeBit(input logic b);
    sdaM = b; waitHalf();
    sclM = 1'b1; waitHalf();
    sclM = 1'b0;
  endtask

  task automatic readBit(output logic lo, output logic hi);
    sdaM = 1'b1;
    repeat (6) @(negedge clk);
    lo = sdaBus;
    repeat (2) @(negedge clk);
    sclM = 1'b1;
    repeat (5) @(negedge clk);
    hi = sdaBus;
    repeat (3) @(negedge clk);
    sclM = 1'b0;
  endtask

  // returns 1 when acknowledged in both low and high phase of the 9th clock
  task automatic sendByte(input logic [7:0] b, output logic ack);
    logic lo, hi;
    for (int i = 7; i >= 0; i--) writeBit(b[i]);
    readBit(lo, hi);
    ack = !lo && !hi;
  endtask

  task automatic recvByte(input logic giveAck, output logic [7:0] v);
    logic lo, hi;
    v = 8'h00;
    for (int i = 0; i < 8; i++) begin
      readBit(lo, hi);
      v = {v[6:0], hi};
    end
    writeBit(!giveAck);
  endtask

  logic       ack;
  logic [7:0] rd;

  initial begin
    for (int i = 0; i < 4; i++) mRegs[i] = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset release multi", pullMulti, 1'b0);
    check("R1 reset release single", pullOne, 1'b0);

    // R1: foreign address, target stays silent
    quiet = 1'b1;
    startCond();
    sendByte(8'h66, ack); check("R1 foreign address not acked", ack, 1'b0);
    sendByte(8'h00, ack); check("R1 later byte not acked", ack, 1'b0);
    stopCond();
    quiet = 1'b0;
    check("R1 no pull during foreign transfer", quietHits, 0);

    // R5/R4/R3: pointer then burst write
    startCond();
    sendByte(8'h54, ack); check("R4 address ack both phases", ack, 1'b1);
    sendByte(8'h01, ack); check("R5 pointer byte acked", ack, 1'b1);
    mPtr = 1;
    sendByte(8'hA5, ack); check("R5 data byte acked", ack, 1'b1);
    mRegs[mPtr] = 8'hA5; mPtr++;
    sendByte(8'h3C, ack); check("R5 burst byte acked", ack, 1'b1);
    mRegs[mPtr] = 8'h3C; mPtr++;
    stopCond();
    check("R13 released after stop", pullMulti, 1'b0);

    // R9/R2/R7/R3: pointer write, repeated start, burst read
    startCond();
    sendByte(8'h54, ack);
    sendByte(8'h01, ack); mPtr = 1;
    startCond();
    sendByte(8'h55, ack); check("R2 repeated start readdressed", ack, 1'b1);
    recvByte(1'b1, rd); check("R9 R7 R3 read at kept pointer", rd, mRegs[mPtr]); mPtr++;
    recvByte(1'b0, rd); check("R7 burst read next register", rd, mRegs[mPtr]); mPtr++;
    stopCond();

    // R9 across stop, R8 release after master NACK
    startCond();
    sendByte(8'h55, ack);
    recvByte(1'b0, rd); check("R9 pointer kept across stop", rd, mRegs[mPtr]); mPtr++;
    recvByte(1'b0, rd); check("R8 released after master NACK", rd, 8'hFF);
    stopCond();

    // R11: pointer past last register
    startCond();
    sendByte(8'h55, ack); check("R11 read address acked", ack, 1'b1);
    recvByte(1'b0, rd); check("R11 out of range read", rd, 8'hFF);
    stopCond();

    // R6: out-of-range pointer byte
    startCond();
    sendByte(8'h54, ack);
    sendByte(8'h04, ack); check("R6 bad pointer NACKed", ack, 1'b0);
    sendByte(8'h12, ack); check("R6 idle after bad pointer", ack, 1'b0);
    stopCond();

    // R6: write running off the end
    startCond();
    sendByte(8'h54, ack);
    sendByte(8'h03, ack); mPtr = 3;
    sendByte(8'h77, ack); check("R5 write last register", ack, 1'b1);
    mRegs[3] = 8'h77; mPtr = 4;
    sendByte(8'h88, ack); check("R6 write past end NACKed", ack, 1'b0);
    stopCond();

    // full readback from register 0
    startCond();
    sendByte(8'h54, ack);
    sendByte(8'h00, ack); mPtr = 0;
    startCond();
    sendByte(8'h55, ack);
    for (int i = 0; i < 4; i++) begin
      recvByte(i != 3, rd);
      check("R7 R6 readback of bank", rd, mRegs[i]);
    end
    stopCond();

    // R10: single-register device, multi device silent (R1)
    quiet = 1'b1;
    startCond();
    sendByte(8'hA2, ack); check("R10 single address acked", ack, 1'b1);
    sendByte(8'h5E, ack); check("R10 direct write acked", ack, 1'b1);
    sendByte(8'hC3, ack); check("R10 second write acked", ack, 1'b1);
    mOne = 8'hC3;
    stopCond();
    startCond();
    sendByte(8'hA3, ack);
    recvByte(1'b1, rd); check("R10 read single register", rd, mOne);
    recvByte(1'b0, rd); check("R10 repeated read same register", rd, mOne);
    stopCond();
    quiet = 1'b0;
    check("R1 multi silent during other device", quietHits, 0);

    // R13: after stop, clocks without a start are ignored
    startCond();
    sendByte(8'h54, ack);
    stopCond();
    quiet = 1'b1;
    sclM = 1'b0;
    sendByte(8'h54, ack); check("R13 idle ignores byte without start", ack, 1'b0);
    sdaM = 1'b1; waitHalf(); sclM = 1'b1; waitHalf();
    quiet = 1'b0;
    check("R13 no drive while idle", quietHits, 0);

    check("R12 drive changes only with SCL low", lowPhaseHits, 0);

    if (!done) begin
      done = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule